// File: doc/BRIEF.md
# Renaming Register File Lock

This block is a register file that removes data hazards between pipelined instructions by renaming. Each architectural register index is translated through a map table into a physical register index. Data lives in a larger physical array, each physical register has a ready (valid) flag, and unallocated physical registers are tracked in a free list held as a bit mask. A pipeline uses the block through lock-style operations. A write reservation allocates a fresh physical name and returns the name it displaced. A read reservation looks up the current name. A read block waits on that name's valid flag. A write access fills a name's data and marks it valid. A write release hands the displaced name back for reuse.

To support speculation, the map table and free list can be copied into one of several snapshot slots and later restored from a chosen slot. Names released after a snapshot is taken are also marked free inside every snapshot, so a rollback never loses a commit that has already happened. A read release needs no action, so the block has no port for it.

Top module: `rename_regfile`

## Requirements
- R1: After reset, architectural register i maps to physical register i, every physical register is valid, and the free names are NARCH up to NPHYS-1.
- R2: When a free name exists and no rollback is requested, `wres_ready` is 1, `wres_phys` is the lowest-numbered free name and `wres_old` is the current mapping of `wres_arch`. When `wres_valid` is also 1, from the next cycle the map points `wres_arch` at `wres_phys`, that name is no longer free and its valid flag is 0.
- R3: With no free name, `wres_ready` is 0 and a write request changes neither the map nor the free list.
- R4: `rres_phys` is the mapping of `rres_arch` as it stood at the start of the cycle. A write reservation in the same cycle does not change it until the next cycle.
- R5: `rd_ready` is 1 when the valid flag of `rd_phys` is set, or when a write access to `rd_phys` happens in the same cycle.
- R6: A write access (`wr_en`) stores `wr_data` at `wr_phys` and sets its valid flag. `rd_data` returns the stored value, or `wr_data` when the same name is written in the same cycle.
- R7: A release (`rel_en`) returns `rel_phys` to the free list from the next cycle, and also marks it free in every snapshot slot.
- R8: A checkpoint (`ck_en`) copies the map table and free list into slot `ck_slot`, as they stand after all of that cycle's updates, including a rollback.
- R9: A rollback (`rb_en`) restores the map table and free list from slot `rb_slot` in the next cycle. In a rollback cycle `wres_ready` is 0, while a release in the same cycle still takes effect. Valid flags are unaffected.
- R10: After reset, every snapshot slot holds the reset map and reset free list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wres_valid | input | 1 | Write reservation request |
| wres_arch | input | AW | Destination architectural register |
| wres_ready | output | 1 | A name can be allocated this cycle |
| wres_phys | output | PW | Newly allocated physical name |
| wres_old | output | PW | Physical name displaced by the reservation |
| rres_arch | input | AW | Source architectural register to look up |
| rres_phys | output | PW | Current physical name of the source |
| rd_phys | input | PW | Physical name to block on and read |
| rd_ready | output | 1 | Read may proceed |
| rd_data | output | DW | Read data, forwarded from a same-cycle write |
| wr_en | input | 1 | Write access |
| wr_phys | input | PW | Physical name written |
| wr_data | input | DW | Data written |
| rel_en | input | 1 | Write release |
| rel_phys | input | PW | Displaced name returned to the free list |
| ck_en | input | 1 | Take a snapshot |
| ck_slot | input | CW | Snapshot slot written |
| rb_en | input | 1 | Roll back |
| rb_slot | input | CW | Snapshot slot restored |

## Verification
The hardest situations to reach are an exhausted free list and a rollback to a slot whose free mask has taken in releases since it was captured. Random stimulus makes write reservations far more often than releases, so the free list drains repeatedly. Checkpoints and rollbacks are scattered through the run, so slots keep collecting late releases. A directed sequence drains the list on purpose, then checks that a refused request leaves the map unchanged and that a rollback brings the speculative names back.

// File: rtl/rename_regfile.sv
module rename_regfile #(
  parameter int NARCH = 8,
  parameter int NPHYS = 16,
  parameter int DW    = 32,
  parameter int NCKPT = 2,
  parameter int AW    = $clog2(NARCH),
  parameter int PW    = $clog2(NPHYS),
  parameter int CW    = (NCKPT > 1) ? $clog2(NCKPT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wres_valid,
  input  logic [AW-1:0] wres_arch,
  output logic          wres_ready,
  output logic [PW-1:0] wres_phys,
  output logic [PW-1:0] wres_old,
  input  logic [AW-1:0] rres_arch,
  output logic [PW-1:0] rres_phys,
  input  logic [PW-1:0] rd_phys,
  output logic          rd_ready,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_phys,
  input  logic [DW-1:0] wr_data,
  input  logic          rel_en,
  input  logic [PW-1:0] rel_phys,
  input  logic          ck_en,
  input  logic [CW-1:0] ck_slot,
  input  logic          rb_en,
  input  logic [CW-1:0] rb_slot
);

  typedef logic [NARCH-1:0][PW-1:0] map_t;

  map_t             map_q, map_n, map_rst;
  logic [NPHYS-1:0] free_q, free_n, free_rst;
  logic [NPHYS-1:0] valid_q, valid_n;
  logic [DW-1:0]    data_q [NPHYS];
  map_t             ck_map  [NCKPT];
  logic [NPHYS-1:0] ck_free [NCKPT];

  logic [PW-1:0] alloc;
  logic          any_free;
  logic          fire;

  always_comb begin
    for (int i = 0; i < NARCH; i++) map_rst[i] = PW'(i);
    for (int i = 0; i < NPHYS; i++) free_rst[i] = (i >= NARCH);
  end

  always_comb begin
    alloc    = '0;
    any_free = 1'b0;
    for (int i = NPHYS-1; i >= 0; i--)
      if (free_q[i]) begin
        alloc    = PW'(i);
        any_free = 1'b1;
      end
  end

  assign wres_ready = any_free && !rb_en;
  assign wres_phys  = alloc;
  assign wres_old   = map_q[wres_arch];
  assign fire       = wres_valid && wres_ready;
  assign rres_phys  = map_q[rres_arch];

  assign rd_ready = valid_q[rd_phys] || (wr_en && wr_phys == rd_phys);
  assign rd_data  = (wr_en && wr_phys == rd_phys) ? wr_data : data_q[rd_phys];

  always_comb begin
    if (rb_en) begin
      map_n  = ck_map[rb_slot];
      free_n = ck_free[rb_slot];
    end else begin
      map_n  = map_q;
      free_n = free_q;
      if (fire) begin
        map_n[wres_arch] = alloc;
        free_n[alloc]    = 1'b0;
      end
    end
    if (rel_en) free_n[rel_phys] = 1'b1;
  end

  always_comb begin
    valid_n = valid_q;
    if (wr_en) valid_n[wr_phys] = 1'b1;
    if (fire)  valid_n[alloc]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q   <= map_rst;
      free_q  <= free_rst;
      valid_q <= '1;
    end else begin
      map_q   <= map_n;
      free_q  <= free_n;
      valid_q <= valid_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) data_q[i] <= '0;
    end else if (wr_en) begin
      data_q[wr_phys] <= wr_data;
    end
  end

  for (genvar k = 0; k < NCKPT; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ck_map[k]  <= map_rst;
        ck_free[k] <= free_rst;
      end else if (ck_en && ck_slot == CW'(k)) begin
        ck_map[k]  <= map_n;
        ck_free[k] <= free_n;
      end else if (rel_en) begin
        ck_free[k][rel_phys] <= 1'b1;
      end
    end
  end

  AST_EMPTY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (free_q == '0) |-> !wres_ready); // R3

  AST_ALLOC_MAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !rb_en) |=> map_q[$past(wres_arch)] == $past(wres_phys)); // R2

  AST_ALLOC_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !(wr_en && wr_phys == wres_phys)) |=> !valid_q[$past(wres_phys)]); // R2

  AST_WRITE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(fire && wres_phys == wr_phys)) |=> valid_q[$past(wr_phys)]); // R6

  AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |=> free_q[$past(rel_phys)]); // R7

  AST_ROLLBACK_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    rb_en |=> map_q == $past(ck_map[rb_slot])); // R9

  AST_ROLLBACK_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    rb_en |-> !wres_ready); // R9

  AST_CKPT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    ck_en |=> ck_map[$past(ck_slot)] == map_q); // R8

endmodule

// File: tb/test_rename_regfile.sv
module test_rename_regfile;
  localparam int NARCH = 8;
  localparam int NPHYS = 16;
  localparam int DW    = 32;
  localparam int NCKPT = 2;
  localparam int AW = 3, PW = 4, CW = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wres_valid = 1'b0;
  logic [AW-1:0] wres_arch = '0;
  logic          wres_ready;
  logic [PW-1:0] wres_phys, wres_old, rres_phys;
  logic [AW-1:0] rres_arch = '0;
  logic [PW-1:0] rd_phys = '0;
  logic          rd_ready;
  logic [DW-1:0] rd_data;
  logic          wr_en = 1'b0;
  logic [PW-1:0] wr_phys = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rel_en = 1'b0;
  logic [PW-1:0] rel_phys = '0;
  logic          ck_en = 1'b0;
  logic [CW-1:0] ck_slot = '0;
  logic          rb_en = 1'b0;
  logic [CW-1:0] rb_slot = '0;

  always #5 clk = ~clk;

  rename_regfile #(.NARCH(NARCH), .NPHYS(NPHYS), .DW(DW), .NCKPT(NCKPT)) i_rename_regfile (
    .clk(clk), .rst_n(rst_n),
    .wres_valid(wres_valid), .wres_arch(wres_arch), .wres_ready(wres_ready),
    .wres_phys(wres_phys), .wres_old(wres_old),
    .rres_arch(rres_arch), .rres_phys(rres_phys),
    .rd_phys(rd_phys), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_en(wr_en), .wr_phys(wr_phys), .wr_data(wr_data),
    .rel_en(rel_en), .rel_phys(rel_phys),
    .ck_en(ck_en), .ck_slot(ck_slot), .rb_en(rb_en), .rb_slot(rb_slot));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int           m_map  [NARCH];
  logic [15:0]  m_free;
  logic [15:0]  m_valid;
  logic [31:0]  m_data [NPHYS];
  int           c_map  [NCKPT][NARCH];
  logic [15:0]  c_free [NCKPT];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lowest_free(input logic [15:0] f);
    for (int i = 0; i < NPHYS; i++) if (f[i]) return i;
    return 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NARCH; i++) m_map[i] = i;
    m_free = '0;
    for (int i = NARCH; i < NPHYS; i++) m_free[i] = 1'b1;
    m_valid = '1;
    for (int i = 0; i < NPHYS; i++) m_data[i] = '0;
    for (int k = 0; k < NCKPT; k++) begin
      for (int i = 0; i < NARCH; i++) c_map[k][i] = m_map[i];
      c_free[k] = m_free;
    end
  endtask

  // Inputs are already set; check outputs, then advance the model.
  task automatic step();
    bit er;
    int ea;
    int nmap [NARCH];
    logic [15:0] nfree, nvalid;
    #1;
    er = (m_free != 0) && !rb_en;
    ea = lowest_free(m_free);
    chk(wres_ready == er, rb_en ? "R9" : (m_free == 0 ? "R3" : "R2"), wres_ready, er);
    if (er) chk(wres_phys == PW'(ea), "R2", wres_phys, ea);
    chk(wres_old == PW'(m_map[wres_arch]), "R2", wres_old, m_map[wres_arch]);
    chk(rres_phys == PW'(m_map[rres_arch]), "R4", rres_phys, m_map[rres_arch]);
    chk(rd_ready == (m_valid[rd_phys] || (wr_en && wr_phys == rd_phys)), "R5",
        rd_ready, m_valid[rd_phys] || (wr_en && wr_phys == rd_phys));
    if (wr_en && wr_phys == rd_phys) chk(rd_data == wr_data, "R6", rd_data, wr_data);
    else chk(rd_data == m_data[rd_phys], "R6", rd_data, m_data[rd_phys]);

    if (rb_en) begin
      for (int i = 0; i < NARCH; i++) nmap[i] = c_map[rb_slot][i];
      nfree = c_free[rb_slot];
    end else begin
      for (int i = 0; i < NARCH; i++) nmap[i] = m_map[i];
      nfree = m_free;
      if (wres_valid && er) begin
        nmap[wres_arch] = ea;
        nfree[ea] = 1'b0;
      end
    end
    if (rel_en) nfree[rel_phys] = 1'b1;
    nvalid = m_valid;
    if (wr_en) begin
      nvalid[wr_phys] = 1'b1;
      m_data[wr_phys] = wr_data;
    end
    if (wres_valid && er) nvalid[ea] = 1'b0;
    for (int k = 0; k < NCKPT; k++) begin
      if (ck_en && ck_slot == CW'(k)) begin
        for (int i = 0; i < NARCH; i++) c_map[k][i] = nmap[i];
        c_free[k] = nfree;
      end else if (rel_en) c_free[k][rel_phys] = 1'b1;
    end
    for (int i = 0; i < NARCH; i++) m_map[i] = nmap[i];
    m_free = nfree;
    m_valid = nvalid;
    @(negedge clk);
  endtask

  task automatic idle();
    wres_valid = 0; wr_en = 0; rel_en = 0; ck_en = 0; rb_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R10: reset state
    for (int i = 0; i < NARCH; i++) begin
      rres_arch = AW'(i); #1;
      chk(rres_phys == PW'(i), "R1", rres_phys, i);
    end
    for (int i = 0; i < NPHYS; i++) begin
      rd_phys = PW'(i); #1;
      chk(rd_ready == 1'b1, "R1", rd_ready, 1);
    end
    #1 chk(wres_phys == PW'(NARCH), "R1", wres_phys, NARCH);
    // R10: roll back to untouched slot 1 restores the reset map
    rb_en = 1; rb_slot = 1; step(); idle();
    for (int i = 0; i < NARCH; i++) begin
      rres_arch = AW'(i); #1;
      chk(rres_phys == PW'(i), "R10", rres_phys, i);
    end
    @(negedge clk);

    // Directed: checkpoint slot 0, drain the free list on arch 3 (R2, R3)
    ck_en = 1; ck_slot = 0; step(); idle();
    for (int n = 0; n < NPHYS - NARCH + 1; n++) begin
      wres_valid = 1; wres_arch = 3; rres_arch = 3; rd_phys = wres_phys; step();
    end
    idle();
    #1 chk(wres_ready == 1'b0, "R3", wres_ready, 0);
    rres_arch = 3; #1 chk(rres_phys == PW'(NPHYS-1), "R3", rres_phys, NPHYS-1);
    @(negedge clk);
    // R6 forward and R5 ready on a pending name
    wr_en = 1; wr_phys = PW'(NPHYS-1); wr_data = 32'hCAFE_F00D; rd_phys = PW'(NPHYS-1); step(); idle();
    rd_phys = PW'(NPHYS-1); step();
    // R7 release, then R9 rollback keeps the release
    rel_en = 1; rel_phys = 3; step(); idle();
    rb_en = 1; rb_slot = 0; wres_valid = 1; step(); idle();
    rres_arch = 3; step();
    chk(m_free[3] == 1'b1, "R7", m_free[3], 1);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      wres_valid = ($urandom % 100) < 60;
      wres_arch  = AW'($urandom);
      rres_arch  = AW'($urandom);
      rd_phys    = PW'($urandom);
      wr_en      = ($urandom % 100) < 40;
      wr_phys    = PW'($urandom);
      wr_data    = $urandom;
      rel_en     = ($urandom % 100) < 12;
      rel_phys   = PW'($urandom);
      ck_en      = ($urandom % 100) < 6;
      ck_slot    = CW'($urandom);
      rb_en      = ($urandom % 100) < 4;
      rb_slot    = CW'($urandom);
      step();
    end
    idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule